// File: doc/BRIEF.md
# Converter Serial Readout Controller

This block is the device-side sequencer of a self-timed analog-to-digital converter. It moves through three phases: converting, sleeping with a finished result, and shifting that result out. The conversion is modelled by a cycle timer. When the timer expires, a supplied result word is framed and captured. A host reads the frame over a three-wire link made of an active-low select, a serial clock and one data line. While no transfer runs, the data line also reports conversion status.

The serial clock pin works in one of two ways. In external mode the host drives it. In internal mode the block drives it itself after a fixed wait, and a weak pull-up is requested on the pin. The mode is taken from the pin level at the end of reset and at every falling edge of select. A rising edge of select during a transfer abandons the read and restarts conversion. If select is tied low, conversions run one after another and the status stays visible.

Top module: `adc_readout_ctrl`

## Requirements
- R1: Phases always run converting → sleeping → shifting → converting. Sleeping is entered CONV_CYCLES cycles after converting begins, at any select level.
- R2: With select high, `sdo_oe` is 0. Serial clock pulses given while select is high leave the captured frame unchanged.
- R3: With select low and no transfer running, the data line carries the status bit: 1 while converting and 0 once a result is waiting.
- R4: In external mode, sleeping is left only on a rising serial clock seen with select low. The frame goes out most significant bit first, one bit per falling clock. The frame is 32 bits: bit 31 = 0 (status), bit 30 = 0 (filler), bits 29..0 = `result_i`.
- R5: The frame holds the value of `result_i` in the cycle the conversion ends. Later changes to `result_i` do not reach that frame.
- R6: On the 32nd falling serial clock of a transfer a new conversion begins, and the data line goes to 1.
- R7: A select rising edge during a transfer ends the transfer at once and starts a new conversion. Select low afterwards shows status 1.
- R8: A serial clock pin that is low at a select falling edge, or at the end of reset, selects external mode (`sck_pu_en` = 0). A high pin selects internal mode (`sck_pu_en` = 1).
- R9: In internal mode with select low, the block drives the serial clock (`sck_oe` = 1), low at first. The first rising clock comes TEST_DELAY cycles (plus synchroniser latency) after select falls, or after the result becomes ready if select was already low. Each clock phase lasts INT_SCK_HALF cycles.
- R10: Reset starts a conversion with the output line released. With select held low from reset, results can be read back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Active-low select from the host |
| sck_pin_in | input | 1 | Level seen on the serial clock pin |
| result_i | input | RES_W | Result word captured when a conversion ends |
| sdo_o | output | 1 | Serial data / status level |
| sdo_oe | output | 1 | Drive enable for the data line |
| sck_o | output | 1 | Serial clock driven in internal mode |
| sck_oe | output | 1 | Drive enable for the serial clock pin |
| sck_pu_en | output | 1 | Weak pull-up request for the clock pin |

## Verification
The bench aborts reads after a random number of bits in both clock modes. A design that kept shifting, or that waited in sleep after an abort, would show status 0 or stale bits where 1 is expected. It toggles the clock while select is high and changes the result word after capture. A design that let either one through would return a corrupted frame. It also sets select low before conversion ends in internal mode, and holds select low from reset in external mode. A design that started its delay only on a select edge, or that took the wrong clock mode at reset, would never start the transfer or would drive the clock pin against the host.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DOUT  = 2'd2
  } rd_state_t;

  // level on the shared data line for a given phase
  function automatic logic line_level(rd_state_t s, logic data_bit);
    case (s)
      ST_CONV:  return 1'b1;
      ST_SLEEP: return 1'b0;
      default:  return data_bit;
    endcase
  endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
      s3 <= RST_VAL;
    end else begin
      s1 <= d;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign q    = s2;
  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!active)         cnt <= '0;
    else if (cnt != LAST)     cnt <= cnt + 1'b1;
  end

  assign done = active && (cnt == LAST);
endmodule

// File: rtl/int_sck_gen.sv
module int_sck_gen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic sck,
  output logic fall_ev
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HW-1:0] LAST = HW'(HALF - 1);

  logic [HW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      sck <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      if (cnt == LAST) begin
        cnt <= '0;
        sck <= ~sck;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      sck <= 1'b0;
      cnt <= '0;
    end
  end

  assign fall_ev = run && sck && (cnt == LAST);
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [W-1:0]         din,
  input  logic                 shift,
  output logic                 msb,
  output logic [$clog2(W)-1:0] bit_cnt,
  output logic                 last_bit
);
  localparam int CW = $clog2(W);

  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      bit_cnt <= '0;
    end else if (load) begin
      sh      <= din;
      bit_cnt <= '0;
    end else if (shift) begin
      sh      <= {sh[W-2:0], 1'b0};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign msb      = sh[W-1];
  assign last_bit = (bit_cnt == CW'(W - 1));
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int RES_W        = 30,
  parameter int CONV_CYCLES  = 20000,
  parameter int TEST_DELAY   = 3000,
  parameter int INT_SCK_HALF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_pin,
  input  logic             sck_pin_in,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o,
  output logic             sdo_oe,
  output logic             sck_o,
  output logic             sck_oe,
  output logic             sck_pu_en
);
  localparam int FRAME_W = RES_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int DLY_W   = $clog2(TEST_DELAY + 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(TEST_DELAY - 1);

  // synchronised pins and their edges
  logic cs_s, cs_rise, cs_fall;
  logic sck_s, sck_rise, sck_fall;

  edge_sync #(.RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .d(cs_n_pin),
    .q(cs_s), .rise(cs_rise), .fall(cs_fall)
  );

  edge_sync #(.RST_VAL(1'b1)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d(sck_pin_in),
    .q(sck_s), .rise(sck_rise), .fall(sck_fall)
  );

  // clock mode: latched after reset settles and on every select fall
  logic [1:0] init_cnt;
  logic       mode_valid;
  logic       ext_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt <= '0;
      ext_mode <= 1'b0;
    end else begin
      if (init_cnt != 2'd3) init_cnt <= init_cnt + 1'b1;
      if (init_cnt == 2'd2 || cs_fall) ext_mode <= ~sck_s;
    end
  end
  assign mode_valid = (init_cnt == 2'd3);

  // phase register and named events
  rd_state_t st, st_nx;
  logic conv_done, ev_eoc_fall, ev_abort, ev_shift;
  logic go_ext, go_int, sleep_wait, int_run, int_fall, int_sck;
  logic sh_msb, last_bit;
  logic [CNT_W-1:0] bit_cnt;
  logic [DLY_W-1:0] dly_cnt;

  conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(st == ST_CONV), .done(conv_done)
  );

  assign sleep_wait = (st == ST_SLEEP) && !cs_s && !ext_mode && mode_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     dly_cnt <= '0;
    else if (!sleep_wait || cs_fall) dly_cnt <= '0;
    else if (dly_cnt != DLY_LAST)    dly_cnt <= dly_cnt + 1'b1;
  end

  assign go_int      = sleep_wait && !cs_fall && (dly_cnt == DLY_LAST);
  assign go_ext      = (st == ST_SLEEP) && !cs_s && ext_mode && mode_valid && sck_rise;
  assign int_run     = (st == ST_DOUT) && !ext_mode;
  assign ev_eoc_fall = (st == ST_CONV) && conv_done;
  assign ev_abort    = (st == ST_DOUT) && cs_rise;
  assign ev_shift    = (st == ST_DOUT) && !cs_rise && (ext_mode ? sck_fall : int_fall);

  int_sck_gen #(.HALF(INT_SCK_HALF)) u_isck (
    .clk(clk), .rst_n(rst_n), .start(go_int), .run(int_run),
    .sck(int_sck), .fall_ev(int_fall)
  );

  frame_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(ev_eoc_fall), .din({2'b00, result_i}),
    .shift(ev_shift && !last_bit),
    .msb(sh_msb), .bit_cnt(bit_cnt), .last_bit(last_bit)
  );

  always_comb begin
    st_nx = st;
    case (st)
      ST_CONV:  if (conv_done) st_nx = ST_SLEEP;
      ST_SLEEP: if (go_ext || go_int) st_nx = ST_DOUT;
      ST_DOUT: begin
        if (ev_abort)                  st_nx = ST_CONV;
        else if (ev_shift && last_bit) st_nx = ST_CONV;
      end
      default:  st_nx = ST_CONV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_CONV;
    else        st <= st_nx;
  end

  assign sdo_o     = line_level(st, sh_msb);
  assign sdo_oe    = ~cs_s;
  assign sck_o     = int_sck;
  assign sck_oe    = mode_valid & ~ext_mode & ~cs_s;
  assign sck_pu_en = ~ext_mode;
endmodule

// File: rtl/adc_readout_chk.sv
module adc_readout_chk
  import adc_rd_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      cs_n_pin,
  input logic      sdo_o,
  input logic      sdo_oe,
  input rd_state_t st,
  input logic      ev_shift,
  input logic      last_bit,
  input logic      ev_abort,
  input logic      sck_rise,
  input logic      ext_mode
);
  // R1: sleeping is only reached from converting
  assert_sleep_after_conv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLEEP && $past(st) != ST_SLEEP) |-> $past(st) == ST_CONV);

  // R1: shifting is only reached from sleeping
  assert_dout_after_sleep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DOUT && $past(st) != ST_DOUT) |-> $past(st) == ST_SLEEP);

  // R2: select held high releases the data line
  assert_line_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_pin && $past(cs_n_pin) && $past(cs_n_pin, 2)) |-> !sdo_oe);

  // R3: status is 1 throughout a conversion
  assert_status_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CONV) |-> sdo_o);

  // R4: external mode leaves sleep only on a clock rise
  assert_ext_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DOUT && $past(st) == ST_SLEEP && $past(ext_mode)) |-> $past(sck_rise));

  // R6: last falling clock restarts conversion with status 1
  assert_restart_after_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_shift && last_bit) |=> (st == ST_CONV && sdo_o));

  // R7: select rise mid-transfer restarts conversion
  assert_abort_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> st == ST_CONV);
endmodule

bind adc_readout_ctrl adc_readout_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin),
  .sdo_o(sdo_o), .sdo_oe(sdo_oe), .st(st),
  .ev_shift(ev_shift), .last_bit(last_bit), .ev_abort(ev_abort),
  .sck_rise(sck_rise), .ext_mode(ext_mode)
);

// File: tb/test_adc_readout_ctrl.sv
module test_adc_readout_ctrl;
  localparam int RES_W = 30;
  localparam int CONV  = 200;
  localparam int TD    = 20;
  localparam int HALF  = 4;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic drv_en = 1'b1;
  logic drv_val = 1'b0;
  logic [RES_W-1:0] res = '0;
  logic sdo_o, sdo_oe, sck_o, sck_oe, sck_pu_en;
  logic sck_pin;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  // pin model: block drive wins, then host drive, else pull-up
  assign sck_pin = sck_oe ? sck_o : (drv_en ? drv_val : 1'b1);

  adc_readout_ctrl #(
    .RES_W(RES_W), .CONV_CYCLES(CONV), .TEST_DELAY(TD), .INT_SCK_HALF(HALF)
  ) i_adc_readout_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sck_pin_in(sck_pin),
    .result_i(res), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .sck_o(sck_o),
    .sck_oe(sck_oe), .sck_pu_en(sck_pu_en)
  );

  function automatic logic [31:0] exp_frame(logic [RES_W-1:0] r);
    logic [31:0] f;
    for (int i = 0; i < 32; i++) f[i] = (i < RES_W) ? r[i] : 1'b0;
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready(input string req);
    int t = 0;
    while (!(sdo_oe && sdo_o == 1'b0) && t < 3 * CONV) begin
      tick(1);
      t++;
    end
    chk(t < 3 * CONV, req, t, CONV);
  endtask

  task automatic ext_read(input int n, input logic [31:0] f);
    for (int i = 0; i < n; i++) begin
      chk(sdo_o == f[31-i], "R4", sdo_o, f[31-i]);
      drv_val = 1'b1;
      tick(6);
      drv_val = 1'b0;
      tick(6);
    end
    if (n == 32) chk(sdo_o == 1'b1, "R6", sdo_o, 1);
  endtask

  task automatic int_read(input int n, input logic [31:0] f, output int first_wait);
    first_wait = 0;
    for (int i = 0; i < n; i++) begin
      int t = 0;
      while (sck_o != 1'b1 && t < 4 * CONV) begin tick(1); t++; end
      if (i == 0) first_wait = t;
      chk(sck_o == 1'b1, "R9", sck_o, 1);
      chk(sdo_o == f[31-i], "R9", sdo_o, f[31-i]);
      if (i != n - 1 || n == 32) begin
        t = 0;
        while (sck_o != 1'b0 && t < 4 * HALF) begin tick(1); t++; end
      end
    end
    if (n == 32) begin
      tick(1);
      chk(sdo_o == 1'b1, "R6", sdo_o, 1);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  initial begin
    logic [RES_W-1:0] captured;
    int fw;
    int seed_dummy;
    seed_dummy = $urandom(1234);
    res = RES_W'($urandom);

    // phase 1: reset with clock pin low, select high (R10, R8)
    tick(5);
    rst_n = 1'b1;
    tick(4);
    chk(sdo_oe == 1'b0, "R10", sdo_oe, 0);
    chk(sck_pu_en == 1'b0, "R8", sck_pu_en, 0);
    cs_n = 1'b0;
    tick(4);
    chk(sdo_oe && sdo_o == 1'b1, "R3", sdo_o, 1);
    chk(sck_oe == 1'b0, "R8", sck_oe, 0);
    wait_ready("R1");
    ext_read(32, exp_frame(res));

    // phase 2: clocks ignored with select high, late result change (R2, R5)
    cs_n = 1'b1;
    tick(3);
    chk(sdo_oe == 1'b0, "R2", sdo_oe, 0);
    captured = res;
    tick(CONV + 20);
    for (int k = 0; k < 8; k++) begin
      drv_val = 1'b1; tick(3); drv_val = 1'b0; tick(3);
    end
    res = ~res;
    cs_n = 1'b0;
    tick(4);
    chk(sdo_o == 1'b0, "R3", sdo_o, 0);
    ext_read(32, exp_frame(captured));

    // phase 3: abort in external mode (R7)
    wait_ready("R1");
    ext_read(5, exp_frame(res));
    cs_n = 1'b1;
    tick(4);
    cs_n = 1'b0;
    tick(4);
    chk(sdo_o == 1'b1, "R7", sdo_o, 1);
    wait_ready("R7");
    ext_read(32, exp_frame(res));

    // phase 4: internal mode entered at select fall (R8, R9)
    cs_n = 1'b1;
    drv_en = 1'b0;
    res = RES_W'($urandom);
    tick(CONV + 20);
    cs_n = 1'b0;
    tick(4);
    chk(sck_oe == 1'b1, "R9", sck_oe, 1);
    chk(sck_o == 1'b0, "R9", sck_o, 0);
    chk(sck_pu_en == 1'b1, "R8", sck_pu_en, 1);
    int_read(32, exp_frame(res), fw);
    chk(fw + 4 >= TD + 2 && fw + 4 <= TD + 4, "R9", fw + 4, TD + 3);

    // phase 5: select low before result ready in internal mode (R9), then abort (R7)
    res = RES_W'($urandom);
    int_read(32, exp_frame(res), fw);
    chk(fw >= CONV, "R9", fw, CONV);
    int_read(7, exp_frame(res), fw);
    cs_n = 1'b1;
    tick(4);
    cs_n = 1'b0;
    tick(4);
    chk(sdo_o == 1'b1, "R7", sdo_o, 1);

    // phase 6: random mix of modes, results and read lengths
    for (int it = 0; it < 8; it++) begin
      bit ext;
      int n;
      ext = $urandom % 2;
      n = ($urandom % 3 == 0) ? 1 + ($urandom % 31) : 32;
      cs_n = 1'b1;
      res = RES_W'($urandom);
      drv_en = ext;
      drv_val = 1'b0;
      tick(CONV + 30 + ($urandom % 50));
      cs_n = 1'b0;
      if (ext) begin
        tick(4);
        chk(sck_pu_en == 1'b0, "R8", sck_pu_en, 0);
        ext_read(n, exp_frame(res));
      end else begin
        int_read(n, exp_frame(res), fw);
      end
      if (n < 32) begin
        cs_n = 1'b1;
        tick(4);
        cs_n = 1'b0;
        tick(4);
        chk(sdo_o == 1'b1, "R7", sdo_o, 1);
      end
    end

    // phase 7: select tied low from reset, back-to-back reads (R10)
    cs_n = 1'b0;
    drv_en = 1'b1;
    drv_val = 1'b0;
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(6);
    chk(sdo_oe == 1'b1 && sdo_o == 1'b1, "R10", sdo_o, 1);
    chk(sck_oe == 1'b0, "R10", sck_oe, 0);
    for (int k = 0; k < 2; k++) begin
      wait_ready("R10");
      ext_read(32, exp_frame(res));
      res = RES_W'($urandom);
    end

    summary();
    $finish;
  end
endmodule